// File: doc/BRIEF.md
# Page access rights checker

This block decides whether a single memory access to a page may proceed. Each request carries the access kind, a 2-bit privilege level, the page's 7-bit rights field taken from a translation entry, the two translation-enable bits of the processor status word, and a probe flag. The block returns three things: an allow flag, a trap class that says which kind of fault to raise, and the privilege level that a gateway branch through the page would run at. Privilege level 0 is the most privileged and level 3 the least, and every comparison uses the plain binary values.

Requests and results move over valid/ready handshakes, and there is one register stage between them. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result appears with `rsp_valid` high from the next cycle and stays stable until a rising edge where `rsp_ready` is high. `req_ready` is high when the result register is empty or is being drained in the same cycle. While `rsp_ready` is low, no request is lost or overwritten. The parameter `REDUCED_PRIV` selects a variant that has only two levels: any non-zero level, in the request and in the rights fields alike, is treated as level 3.

Top module: `page_rights_check`

## Requirements
- R1: The rights field is laid out as bits [6:4] page type, [3:2] upper bound UB, and [1:0] lower bound LB. The page types give these permissions: 000 read only, 001 read/write, 010 read/execute, 011 read/write/execute, and 100 to 111 execute only.
- R2: A read (req_kind 00) is allowed when the type permits read and PL <= UB.
- R3: A write (req_kind 01) is allowed when the type permits write and PL <= LB.
- R4: An execute (req_kind 10) is allowed when the type permits execute and LB <= PL <= UB, so a level that is too privileged is refused as well as one that is not privileged enough.
- R5: A semaphore access (req_kind 11) is allowed only when both the read rule and the write rule pass.
- R6: If the request is not a probe, an execute with psw_code_xlate = 0 is always allowed, and a read, write or semaphore with psw_data_xlate = 0 is always allowed. The other enable bit has no effect.
- R7: A probe (req_probe = 1) always applies the rules, whatever the enable bits are, using req_pl. It reports its verdict on rsp_allow and always returns rsp_trap = 00.
- R8: rsp_trap is 00 when the access is allowed, 01 (instruction protection fault) when a non-probe execute is refused, and 10 (data access-rights fault) when a non-probe read, write or semaphore is refused.
- R9: rsp_gate_pl is the smaller of PL and type[1:0] when the type is 1xx, and PL otherwise. A gateway therefore never lowers privilege.
- R10: When REDUCED_PRIV = 1, PL, UB, LB and the gateway target are each mapped to 3 if non-zero before they are used.
- R11: A request accepted on an edge produces rsp_valid on the next cycle. While rsp_valid is high and rsp_ready is low, the outputs hold steady and req_ready is low.
- R12: After reset, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | 00 read, 01 write, 10 execute, 11 semaphore |
| req_pl | input | 2 | Privilege level (instruction's or probe-supplied) |
| req_rights | input | 7 | Page rights field |
| req_probe | input | 1 | Probe access: always checked, never traps |
| psw_code_xlate | input | 1 | Execute checks enabled |
| psw_data_xlate | input | 1 | Data checks enabled |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_allow | output | 1 | Access allowed |
| rsp_trap | output | 2 | Trap class |
| rsp_gate_pl | output | 2 | Privilege level after a gateway |

## Verification
The hardest case to reach is a result held under back-pressure while the next request is already waiting. The bench holds rsp_ready low, lets one result fill the register, and then offers a second request with different fields for several cycles. It checks that the first result stays intact and that req_ready stays low. When rsp_ready is raised, the drain of the first result and the acceptance of the second happen on the same edge, and the bench checks that exactly the second result follows. The two-sided execute window is covered from both sides, and a second instance with REDUCED_PRIV = 1 is driven with the same stimulus.

// File: rtl/page_rights_pkg.sv
package page_rights_pkg;
  localparam int PL_W    = 2;
  localparam int TYPE_W  = 3;
  localparam int RIGHTS_W = TYPE_W + 2 * PL_W;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_EXEC  = 2'b10,
    KIND_SEM   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    TRAP_NONE = 2'b00,
    TRAP_INSN = 2'b01,
    TRAP_DATA = 2'b10
  } trap_e;

  typedef struct packed {
    logic [TYPE_W-1:0] ptype;
    logic [PL_W-1:0]   ub;
    logic [PL_W-1:0]   lb;
  } rights_t;

  typedef struct packed {
    logic can_rd;
    logic can_wr;
    logic can_ex;
    logic is_gate;
  } perm_t;
endpackage

// File: rtl/pl_fold.sv
module pl_fold #(
  parameter bit REDUCED = 1'b0,
  parameter int W = 2
) (
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] lvl_out
);
  generate
    if (REDUCED) begin : g_fold
      assign lvl_out = (lvl_in == '0) ? '0 : '1;
    end else begin : g_pass
      assign lvl_out = lvl_in;
    end
  endgenerate
endmodule

// File: rtl/rights_decode.sv
module rights_decode
  import page_rights_pkg::*;
(
  input  logic [TYPE_W-1:0] ptype,
  output perm_t             perm
);
  always_comb begin
    perm.is_gate = ptype[TYPE_W-1];
    perm.can_rd  = !ptype[TYPE_W-1];
    perm.can_wr  = !ptype[TYPE_W-1] && ptype[0];
    perm.can_ex  = ptype[TYPE_W-1] || ptype[1];
    // R1: execute-only pages never permit data access
    assert_gate_no_data_R1: assert (!(perm.is_gate && (perm.can_rd || perm.can_wr)));
  end
endmodule

// File: rtl/rights_verdict.sv
module rights_verdict
  import page_rights_pkg::*;
#(
  parameter int W = PL_W
) (
  input  perm_t        perm,
  input  logic [1:0]   kind,
  input  logic [W-1:0] pl,
  input  logic [W-1:0] ub,
  input  logic [W-1:0] lb,
  input  logic         probe,
  input  logic         code_en,
  input  logic         data_en,
  output logic         allow,
  output logic [1:0]   trap
);
  logic rd_ok, wr_ok, ex_ok, rule_ok, check_on, is_exec;

  always_comb begin
    rd_ok   = perm.can_rd && (pl <= ub);
    wr_ok   = perm.can_wr && (pl <= lb);
    ex_ok   = perm.can_ex && (pl <= ub) && (pl >= lb);
    is_exec = (kind == KIND_EXEC);
    unique case (kind)
      KIND_READ:  rule_ok = rd_ok;
      KIND_WRITE: rule_ok = wr_ok;
      KIND_EXEC:  rule_ok = ex_ok;
      default:    rule_ok = rd_ok && wr_ok;
    endcase
    check_on = probe || (is_exec ? code_en : data_en);
    allow    = !check_on || rule_ok;
    if (allow || probe)  trap = TRAP_NONE;
    else if (is_exec)    trap = TRAP_INSN;
    else                 trap = TRAP_DATA;
    // R5: a semaphore passing implies both data rules pass when checked
    assert_sem_both_R5: assert (!(kind == KIND_SEM && check_on && allow) || (rd_ok && wr_ok));
  end
endmodule

// File: rtl/page_rights_check.sv
module page_rights_check
  import page_rights_pkg::*;
#(
  parameter bit REDUCED_PRIV = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [PL_W-1:0]     req_pl,
  input  logic [RIGHTS_W-1:0] req_rights,
  input  logic                req_probe,
  input  logic                psw_code_xlate,
  input  logic                psw_data_xlate,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_allow,
  output logic [1:0]          rsp_trap,
  output logic [PL_W-1:0]     rsp_gate_pl
);
  rights_t         rf;
  perm_t           perm;
  logic [PL_W-1:0] pl_f, ub_f, lb_f, tgt_f, gate_pl;
  logic            allow_c;
  logic [1:0]      trap_c;
  logic            accept;
  logic            rsp_probe_q;

  assign rf = rights_t'(req_rights);

  pl_fold #(.REDUCED(REDUCED_PRIV), .W(PL_W)) u_fold_pl  (.lvl_in(req_pl),                 .lvl_out(pl_f));
  pl_fold #(.REDUCED(REDUCED_PRIV), .W(PL_W)) u_fold_ub  (.lvl_in(rf.ub),                  .lvl_out(ub_f));
  pl_fold #(.REDUCED(REDUCED_PRIV), .W(PL_W)) u_fold_lb  (.lvl_in(rf.lb),                  .lvl_out(lb_f));
  pl_fold #(.REDUCED(REDUCED_PRIV), .W(PL_W)) u_fold_tgt (.lvl_in(rf.ptype[PL_W-1:0]),     .lvl_out(tgt_f));

  rights_decode u_dec (.ptype(rf.ptype), .perm(perm));

  rights_verdict #(.W(PL_W)) u_verdict (
    .perm(perm), .kind(req_kind), .pl(pl_f), .ub(ub_f), .lb(lb_f),
    .probe(req_probe), .code_en(psw_code_xlate), .data_en(psw_data_xlate),
    .allow(allow_c), .trap(trap_c)
  );

  always_comb begin
    gate_pl = (perm.is_gate && (tgt_f < pl_f)) ? tgt_f : pl_f;
    // R9: a gateway never makes the level less privileged
    assert_gate_no_demote_R9: assert (gate_pl <= pl_f);
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_allow   <= 1'b0;
      rsp_trap    <= TRAP_NONE;
      rsp_gate_pl <= '0;
      rsp_probe_q <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_allow   <= allow_c;
      rsp_trap    <= trap_c;
      rsp_gate_pl <= gate_pl;
      rsp_probe_q <= req_probe;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  assert_accept_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_allow) && $stable(rsp_trap) && $stable(rsp_gate_pl)));
  assert_probe_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_probe_q) |-> (rsp_trap == TRAP_NONE));
  assert_trap_only_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap != TRAP_NONE) |-> !rsp_allow);
endmodule

// File: tb/page_rights_check_bench.sv
module page_rights_check_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_kind = 2'b00, req_pl = 2'b00;
  logic [6:0] req_rights = 7'd0;
  logic req_probe = 1'b0, cx = 1'b1, dx = 1'b1;
  logic req_ready, rsp_valid, rsp_allow;
  logic [1:0] rsp_trap, rsp_gate_pl;
  logic r_req_ready, r_rsp_valid, r_rsp_allow;
  logic [1:0] r_rsp_trap, r_rsp_gate_pl;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  page_rights_check u_page_rights_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_pl(req_pl), .req_rights(req_rights), .req_probe(req_probe),
    .psw_code_xlate(cx), .psw_data_xlate(dx), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_allow(rsp_allow), .rsp_trap(rsp_trap), .rsp_gate_pl(rsp_gate_pl));

  page_rights_check #(.REDUCED_PRIV(1'b1)) u_reduced (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r_req_ready),
    .req_kind(req_kind), .req_pl(req_pl), .req_rights(req_rights), .req_probe(req_probe),
    .psw_code_xlate(cx), .psw_data_xlate(dx), .rsp_valid(r_rsp_valid), .rsp_ready(rsp_ready),
    .rsp_allow(r_rsp_allow), .rsp_trap(r_rsp_trap), .rsp_gate_pl(r_rsp_gate_pl));

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [6:0] rf(input logic [2:0] t, input logic [1:0] ub, input logic [1:0] lb);
    return {t, ub, lb};
  endfunction

  // drive on negedge, accept at posedge, result visible at following negedge
  task automatic issue(input logic [1:0] k, input logic [1:0] pl, input logic [6:0] r,
                       input logic pr, input logic c, input logic d);
    @(negedge clk);
    req_kind = k; req_pl = pl; req_rights = r; req_probe = pr; cx = c; dx = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic a, input logic [1:0] t);
    check({tag, " valid"}, rsp_valid, 1);
    check({tag, " allow"}, rsp_allow, a);
    check({tag, " trap"}, rsp_trap, t);
  endtask

  task automatic t_reset();
    check("R12 rsp_valid after reset", rsp_valid, 0);
    check("R12 req_ready after reset", req_ready, 1);
  endtask

  task automatic t_read();
    issue(2'b00, 2'd2, rf(3'b000, 2'd2, 2'd0), 0, 1, 1); expect_rsp("R2 read at bound", 1, 2'b00);
    issue(2'b00, 2'd3, rf(3'b000, 2'd2, 2'd0), 0, 1, 1); expect_rsp("R2 read too low", 0, 2'b10);
    issue(2'b00, 2'd0, rf(3'b100, 2'd3, 2'd0), 0, 1, 1); expect_rsp("R1 read exec-only", 0, 2'b10);
  endtask

  task automatic t_write();
    issue(2'b01, 2'd1, rf(3'b001, 2'd3, 2'd1), 0, 1, 1); expect_rsp("R3 write at bound", 1, 2'b00);
    issue(2'b01, 2'd2, rf(3'b001, 2'd3, 2'd1), 0, 1, 1); expect_rsp("R3 write too low", 0, 2'b10);
    issue(2'b01, 2'd0, rf(3'b000, 2'd3, 2'd3), 0, 1, 1); expect_rsp("R1 write read-only", 0, 2'b10);
    issue(2'b01, 2'd0, rf(3'b010, 2'd3, 2'd3), 0, 1, 1); expect_rsp("R1 write read/exec", 0, 2'b10);
  endtask

  task automatic t_exec();
    issue(2'b10, 2'd1, rf(3'b011, 2'd2, 2'd1), 0, 1, 1); expect_rsp("R4 exec low edge", 1, 2'b00);
    issue(2'b10, 2'd2, rf(3'b011, 2'd2, 2'd1), 0, 1, 1); expect_rsp("R4 exec high edge", 1, 2'b00);
    issue(2'b10, 2'd0, rf(3'b011, 2'd2, 2'd1), 0, 1, 1); expect_rsp("R4 exec too privileged", 0, 2'b01);
    issue(2'b10, 2'd3, rf(3'b011, 2'd2, 2'd1), 0, 1, 1); expect_rsp("R4 exec not privileged", 0, 2'b01);
    issue(2'b10, 2'd0, rf(3'b000, 2'd3, 2'd0), 0, 1, 1); expect_rsp("R8 exec on data page", 0, 2'b01);
    issue(2'b10, 2'd3, rf(3'b110, 2'd3, 2'd0), 0, 1, 1); expect_rsp("R4 exec-only page", 1, 2'b00);
  endtask

  task automatic t_sem();
    issue(2'b11, 2'd1, rf(3'b001, 2'd3, 2'd1), 0, 1, 1); expect_rsp("R5 sem both ok", 1, 2'b00);
    issue(2'b11, 2'd2, rf(3'b001, 2'd3, 2'd0), 0, 1, 1); expect_rsp("R5 sem write fails", 0, 2'b10);
    issue(2'b11, 2'd0, rf(3'b010, 2'd3, 2'd3), 0, 1, 1); expect_rsp("R5 sem no write perm", 0, 2'b10);
  endtask

  task automatic t_disable();
    issue(2'b10, 2'd3, rf(3'b000, 2'd0, 2'd0), 0, 0, 1); expect_rsp("R6 exec code off", 1, 2'b00);
    issue(2'b00, 2'd3, rf(3'b100, 2'd0, 2'd0), 0, 1, 0); expect_rsp("R6 read data off", 1, 2'b00);
    issue(2'b01, 2'd0, rf(3'b000, 2'd3, 2'd3), 0, 0, 1); expect_rsp("R6 write ignores code bit", 0, 2'b10);
    issue(2'b10, 2'd0, rf(3'b000, 2'd3, 2'd0), 0, 1, 0); expect_rsp("R6 exec ignores data bit", 0, 2'b01);
  endtask

  task automatic t_probe();
    issue(2'b00, 2'd0, rf(3'b100, 2'd3, 2'd0), 1, 0, 0); expect_rsp("R7 probe read denied", 0, 2'b00);
    issue(2'b01, 2'd3, rf(3'b001, 2'd3, 2'd3), 1, 0, 0); expect_rsp("R7 probe write allowed", 1, 2'b00);
    issue(2'b01, 2'd2, rf(3'b001, 2'd3, 2'd1), 1, 1, 1); expect_rsp("R7 probe uses given level", 0, 2'b00);
  endtask

  task automatic t_gateway();
    issue(2'b10, 2'd2, rf(3'b100, 2'd3, 2'd0), 0, 1, 1); check("R9 promote to 0", rsp_gate_pl, 0);
    issue(2'b10, 2'd1, rf(3'b111, 2'd3, 2'd0), 0, 1, 1); check("R9 no demotion", rsp_gate_pl, 1);
    issue(2'b10, 2'd3, rf(3'b110, 2'd3, 2'd0), 0, 1, 1); check("R9 promote to 2", rsp_gate_pl, 2);
    issue(2'b10, 2'd2, rf(3'b010, 2'd3, 2'd0), 0, 1, 1); check("R9 non-gate keeps level", rsp_gate_pl, 2);
  endtask

  task automatic t_reduced();
    issue(2'b00, 2'd2, rf(3'b000, 2'd1, 2'd0), 0, 1, 1);
    check("R10 full mode denies", rsp_allow, 0);
    check("R10 reduced mode allows", r_rsp_allow, 1);
    issue(2'b10, 2'd2, rf(3'b101, 2'd3, 2'd0), 0, 1, 1);
    check("R10 reduced gate level", r_rsp_gate_pl, 3);
    issue(2'b10, 2'd1, rf(3'b100, 2'd3, 2'd2), 0, 1, 1);
    check("R10 reduced exec window", r_rsp_allow, 1);
    check("R10 reduced gate to 0", r_rsp_gate_pl, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    issue(2'b00, 2'd3, rf(3'b000, 2'd0, 2'd0), 0, 1, 1);   // A: denied read
    check("R11 A valid", rsp_valid, 1);
    check("R11 ready low while full", req_ready, 0);
    req_kind = 2'b01; req_pl = 2'd0; req_rights = rf(3'b001, 2'd3, 2'd3);
    req_probe = 0; req_valid = 1'b1;                      // B: allowed write
    repeat (3) @(negedge clk);
    check("R11 A held allow", rsp_allow, 0);
    check("R11 A held trap", rsp_trap, 2);
    check("R11 ready still low", req_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R11 B follows", 1, 2'b00);
    @(negedge clk);
    check("R11 drained", rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_exec();
    t_sem();
    t_disable();
    t_probe();
    t_gateway();
    t_reduced();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule